// File: doc/BRIEF.md
# Vendor capability scanner

This block walks a PCI capability linked list through a dword read port into configuration space. A walk starts when `start` is pulsed: the block fetches the list head pointer, then visits capabilities one by one, following each next pointer. It looks for vendor-specific capabilities that say where the device's register structures are. For each of the five structure kinds (common settings, notification, interrupt status, device-specific, configuration-access window) it keeps the first acceptable entry in list order, which is the device's stated preference. It records that entry's BAR index, offset and length. For the notification kind it also records the queue-address multiplier.

Entries with a reserved structure kind or a reserved BAR index are skipped. The block then reports which kinds were found and whether every mandatory kind is present. A list that loops forever is cut off by a hop limit, and the block flags an error. The results stay valid until the next walk and are meant to be consumed when `done` pulses.

Top module: `vcs_scanner`

## Requirements
- R1: A walk first reads the dword at configuration byte address 0x34. Byte 0 of that dword, with its two low bits cleared, is the first capability pointer. A pointer of 0 ends the walk with nothing found, after exactly one read.
- R2: A capability header is the dword at the pointer. Its bytes are: [7:0] capability ID, [15:8] next pointer (two low bits cleared before use), [23:16] capability length, [31:24] structure kind. Only an ID of 0x09 is examined further. Any other ID is skipped by following its next pointer.
- R3: Structure kind 1 maps to slot 0 (common), 2 to slot 1 (notify), 3 to slot 2 (ISR), 4 to slot 3 (device-specific) and 5 to slot 4 (config access). Any other kind is ignored.
- R4: Byte 0 of the dword at pointer+4 is the BAR index. A value above 5 makes the entry ignored, and its slot stays unchanged.
- R5: For an accepted entry, the dword at pointer+8 is the offset and the dword at pointer+12 is the length. Only the first accepted entry of each kind in list order is kept. Later entries of a kind already found are not read beyond their header.
- R6: For a notify entry, the dword at pointer+16 is latched as the multiplier on `notify_mult`. That output is 0 when no notify entry was kept.
- R7: The capability length byte is not checked, so any value, including one larger than the base structure, is accepted.
- R8: `mandatory_ok` is 1 exactly when slots 0, 1, 2 and 4 are found. Slot 3 is optional.
- R9: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse that ends every walk. A next pointer of 0 ends the walk normally.
- R10: A walk visits at most 48 capabilities. If a 49th would follow, `walk_err` is raised and the walk ends. Entries already kept remain, and `walk_err` holds until the next walk starts.
- R11: Reads are issued one at a time as a single-cycle `cfg_rd_req` with a dword-aligned `cfg_rd_addr`. Only `busy` walks issue them. The response `cfg_rd_valid` may arrive in the request cycle or any later cycle.
- R12: `start` is ignored while a walk is in progress. A new walk clears all slots, `walk_err` and the hop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| cfg_rd_req | output | 1 | Single-cycle configuration read request |
| cfg_rd_addr | output | CFG_AW | Dword-aligned configuration byte address |
| cfg_rd_data | input | 32 | Read data, little-endian dword |
| cfg_rd_valid | input | 1 | Read data valid, once per request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| walk_err | output | 1 | Hop limit exceeded on the last walk |
| found | output | 5 | Per-slot entry-kept flags |
| mandatory_ok | output | 1 | All mandatory kinds found |
| ent_bar | output | 5x3 | Per-slot BAR index |
| ent_off | output | 5x32 | Per-slot structure offset |
| ent_len | output | 5x32 | Per-slot structure length |
| notify_mult | output | 32 | Multiplier from the kept notify entry |

## Verification
The assertions assume that the configuration responder answers every request exactly once. They also assume it raises `cfg_rd_valid` only while a request is outstanding, and never without one. The bench responder holds to this: it keeps one captured address, answers it after zero to two cycles, and asserts valid for a single cycle. The stimulus lists cover filtered IDs, reserved kinds and BARs, duplicates, masked pointer bits, an empty list and a two-node loop. Each walk's outcome and read count are compared against a behavioural list walk.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int NTYPES = 5;
  localparam int IDX_COMMON = 0;
  localparam int IDX_NOTIFY = 1;
  localparam int IDX_ISR    = 2;
  localparam int IDX_DEVICE = 3;
  localparam int IDX_ACCESS = 4;
  localparam logic [7:0] VNDR_ID = 8'h09;
  localparam logic [7:0] MAX_BAR = 8'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PTR, ST_HOP, ST_HDR, ST_BAR, ST_OFF, ST_LEN, ST_MUL, ST_FIN
  } walk_st_t;

  typedef struct packed {
    logic [2:0]  bar;
    logic [31:0] off;
    logic [31:0] len;
    logic [31:0] mult;
  } cap_ent_t;
endpackage

// File: rtl/vcs_hop_guard.sv
module vcs_hop_guard #(
  parameter int MAX_HOPS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  logic [CW-1:0] cnt;

  assign at_limit = (cnt == CW'(MAX_HOPS));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !at_limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vcs_entry_bank.sv
module vcs_entry_bank import vcs_pkg::*; (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    commit,
  input  logic [2:0]              commit_idx,
  input  cap_ent_t                commit_ent,
  output logic [NTYPES-1:0]       found,
  output logic [NTYPES-1:0][2:0]  ent_bar,
  output logic [NTYPES-1:0][31:0] ent_off,
  output logic [NTYPES-1:0][31:0] ent_len,
  output logic [31:0]             notify_mult,
  output logic                    mandatory_ok
);
  for (genvar i = 0; i < NTYPES; i++) begin : g_slot
    logic        f_q;
    logic [2:0]  b_q;
    logic [31:0] o_q;
    logic [31:0] l_q;
    logic        hit;

    // first accepted entry wins; later commits to a filled slot are dropped
    assign hit = commit && (commit_idx == 3'(i)) && !f_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        f_q <= 1'b0;
        b_q <= '0;
        o_q <= '0;
        l_q <= '0;
      end else if (hit) begin
        f_q <= 1'b1;
        b_q <= commit_ent.bar;
        o_q <= commit_ent.off;
        l_q <= commit_ent.len;
      end
    end

    assign found[i]   = f_q;
    assign ent_bar[i] = b_q;
    assign ent_off[i] = o_q;
    assign ent_len[i] = l_q;

    if (i == IDX_NOTIFY) begin : g_mul
      logic [31:0] m_q;
      always_ff @(posedge clk) begin
        if (rst || clr) m_q <= '0;
        else if (hit)   m_q <= commit_ent.mult;
      end
      assign notify_mult = m_q;
    end
  end

  assign mandatory_ok = found[IDX_COMMON] & found[IDX_NOTIFY] &
                        found[IDX_ISR] & found[IDX_ACCESS];
endmodule

// File: rtl/vcs_walker.sv
module vcs_walker import vcs_pkg::*; #(
  parameter int         CFG_AW   = 8,
  parameter logic [7:0] PTR_ADDR = 8'h34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [CFG_AW-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              rd_valid,
  input  logic [NTYPES-1:0] found_in,
  input  logic              hop_limit,
  output logic              hop_inc,
  output logic              clr,
  output logic              commit,
  output logic [2:0]        commit_idx,
  output cap_ent_t          commit_ent,
  output logic              busy,
  output logic              done,
  output logic              walk_err
);
  walk_st_t st;
  logic [7:0] ptr;
  logic [7:0] nxt;
  logic [2:0] cidx;
  cap_ent_t   ent;

  logic [7:0] hdr_kind;
  logic       kind_ok;
  logic [2:0] hdr_idx;
  logic       already;
  logic [7:0] hdr_next;
  logic       hdr_take;

  function automatic logic [CFG_AW-1:0] to_addr(input logic [7:0] b);
    return CFG_AW'(b);
  endfunction

  assign hdr_kind = rd_data[31:24];
  assign kind_ok  = (hdr_kind >= 8'd1) && (hdr_kind <= 8'(NTYPES));
  assign hdr_idx  = 3'(hdr_kind - 8'd1);
  assign already  = |(found_in & (NTYPES'(1) << hdr_idx));
  assign hdr_next = {rd_data[15:10], 2'b00};
  // capability length byte [23:16] is deliberately not examined
  assign hdr_take = (rd_data[7:0] == VNDR_ID) && kind_ok && !already;

  assign busy       = (st != ST_IDLE);
  assign clr        = (st == ST_IDLE) && start;
  assign commit_idx = cidx;
  assign commit_ent = ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      nxt      <= '0;
      cidx     <= '0;
      ent      <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      hop_inc  <= 1'b0;
      commit   <= 1'b0;
      done     <= 1'b0;
      walk_err <= 1'b0;
    end else begin
      rd_req  <= 1'b0;
      hop_inc <= 1'b0;
      commit  <= 1'b0;
      done    <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          walk_err <= 1'b0;
          rd_req   <= 1'b1;
          rd_addr  <= to_addr(PTR_ADDR);
          st       <= ST_PTR;
        end
        ST_PTR: if (rd_valid) begin
          ptr <= {rd_data[7:2], 2'b00};
          st  <= ST_HOP;
        end
        ST_HOP: begin
          if (ptr == 8'd0) begin
            st <= ST_FIN;
          end else if (hop_limit) begin
            walk_err <= 1'b1;
            st       <= ST_FIN;
          end else begin
            hop_inc <= 1'b1;
            rd_req  <= 1'b1;
            rd_addr <= to_addr(ptr);
            st      <= ST_HDR;
          end
        end
        ST_HDR: if (rd_valid) begin
          nxt  <= hdr_next;
          cidx <= hdr_idx;
          if (hdr_take) begin
            rd_req  <= 1'b1;
            rd_addr <= to_addr(ptr + 8'd4);
            st      <= ST_BAR;
          end else begin
            ptr <= hdr_next;
            st  <= ST_HOP;
          end
        end
        ST_BAR: if (rd_valid) begin
          if (rd_data[7:0] <= MAX_BAR) begin
            ent.bar  <= rd_data[2:0];
            ent.mult <= '0;
            rd_req   <= 1'b1;
            rd_addr  <= to_addr(ptr + 8'd8);
            st       <= ST_OFF;
          end else begin
            ptr <= nxt;
            st  <= ST_HOP;
          end
        end
        ST_OFF: if (rd_valid) begin
          ent.off <= rd_data;
          rd_req  <= 1'b1;
          rd_addr <= to_addr(ptr + 8'd12);
          st      <= ST_LEN;
        end
        ST_LEN: if (rd_valid) begin
          ent.len <= rd_data;
          if (cidx == 3'(IDX_NOTIFY)) begin
            rd_req  <= 1'b1;
            rd_addr <= to_addr(ptr + 8'd16);
            st      <= ST_MUL;
          end else begin
            commit <= 1'b1;
            ptr    <= nxt;
            st     <= ST_HOP;
          end
        end
        ST_MUL: if (rd_valid) begin
          ent.mult <= rd_data;
          commit   <= 1'b1;
          ptr      <= nxt;
          st       <= ST_HOP;
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcs_scanner.sv
module vcs_scanner import vcs_pkg::*; #(
  parameter int         CFG_AW   = 8,
  parameter logic [7:0] PTR_ADDR = 8'h34,
  parameter int         MAX_HOPS = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    cfg_rd_req,
  output logic [CFG_AW-1:0]       cfg_rd_addr,
  input  logic [31:0]             cfg_rd_data,
  input  logic                    cfg_rd_valid,
  output logic                    busy,
  output logic                    done,
  output logic                    walk_err,
  output logic [NTYPES-1:0]       found,
  output logic                    mandatory_ok,
  output logic [NTYPES-1:0][2:0]  ent_bar,
  output logic [NTYPES-1:0][31:0] ent_off,
  output logic [NTYPES-1:0][31:0] ent_len,
  output logic [31:0]             notify_mult
);
  logic       hop_limit;
  logic       hop_inc;
  logic       clr;
  logic       commit;
  logic [2:0] commit_idx;
  cap_ent_t   commit_ent;

  vcs_walker #(.CFG_AW(CFG_AW), .PTR_ADDR(PTR_ADDR)) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .rd_req(cfg_rd_req), .rd_addr(cfg_rd_addr),
    .rd_data(cfg_rd_data), .rd_valid(cfg_rd_valid),
    .found_in(found), .hop_limit(hop_limit), .hop_inc(hop_inc), .clr(clr),
    .commit(commit), .commit_idx(commit_idx), .commit_ent(commit_ent),
    .busy(busy), .done(done), .walk_err(walk_err)
  );

  vcs_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst(rst), .clr(clr), .inc(hop_inc), .at_limit(hop_limit)
  );

  vcs_entry_bank u_bank (
    .clk(clk), .rst(rst), .clr(clr),
    .commit(commit), .commit_idx(commit_idx), .commit_ent(commit_ent),
    .found(found), .ent_bar(ent_bar), .ent_off(ent_off), .ent_len(ent_len),
    .notify_mult(notify_mult), .mandatory_ok(mandatory_ok)
  );
endmodule

// File: rtl/vcs_scanner_chk.sv
module vcs_scanner_chk import vcs_pkg::*; #(
  parameter int CFG_AW = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    cfg_rd_req,
  input logic [CFG_AW-1:0]       cfg_rd_addr,
  input logic                    cfg_rd_valid,
  input logic                    busy,
  input logic                    done,
  input logic                    walk_err,
  input logic [NTYPES-1:0]       found,
  input logic                    mandatory_ok,
  input logic [NTYPES-1:0][2:0]  ent_bar,
  input logic [NTYPES-1:0][31:0] ent_off,
  input logic [NTYPES-1:0][31:0] ent_len
);
  logic outst;
  always_ff @(posedge clk) begin
    if (rst) outst <= 1'b0;
    else     outst <= (outst | cfg_rd_req) & ~cfg_rd_valid;
  end

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_req |-> !outst);
  a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_req |-> (cfg_rd_addr[1:0] == 2'b00));
  a_r11_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_req |-> busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_found_monotonic: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (($past(found) & ~found) == '0));
  a_r8_mand_rises_in_walk: assert property (@(posedge clk) disable iff (rst)
    $rose(mandatory_ok) |-> busy);
  a_r10_err_hold: assert property (@(posedge clk) disable iff (rst)
    (walk_err && !start) |=> walk_err);

  for (genvar i = 0; i < NTYPES; i++) begin : g_keep
    a_r5_first_kept: assert property (@(posedge clk) disable iff (rst)
      (found[i] && $past(found[i])) |->
        ($stable(ent_bar[i]) && $stable(ent_off[i]) && $stable(ent_len[i])));
  end
endmodule

bind vcs_scanner vcs_scanner_chk #(.CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_valid(cfg_rd_valid),
  .busy(busy), .done(done), .walk_err(walk_err),
  .found(found), .mandatory_ok(mandatory_ok),
  .ent_bar(ent_bar), .ent_off(ent_off), .ent_len(ent_len)
);

// File: tb/vcs_scanner_tb.sv
module vcs_scanner_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_rd_req;
  logic [7:0] cfg_rd_addr;
  logic [31:0] cfg_rd_data = '0;
  logic cfg_rd_valid = 1'b0;
  logic busy, done, walk_err, mandatory_ok;
  logic [4:0] found;
  logic [4:0][2:0] ent_bar;
  logic [4:0][31:0] ent_off, ent_len;
  logic [31:0] notify_mult;

  always #2.5 clk = ~clk;

  vcs_scanner u_dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .cfg_rd_valid(cfg_rd_valid),
    .busy(busy), .done(done), .walk_err(walk_err), .found(found),
    .mandatory_ok(mandatory_ok), .ent_bar(ent_bar), .ent_off(ent_off),
    .ent_len(ent_len), .notify_mult(notify_mult)
  );

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  int seed = 0;
  bit running = 1'b0;

  logic [7:0] cfg [0:255];
  bit [4:0] exp_found;
  logic [2:0] exp_bar [0:4];
  logic [31:0] exp_off [0:4];
  logic [31:0] exp_len [0:4];
  logic [31:0] exp_mult;
  bit exp_err;
  int exp_reads;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {cfg[(a+3)&255], cfg[(a+2)&255], cfg[(a+1)&255], cfg[a&255]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) cfg[(a+k)&255] = v[8*k +: 8];
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < 256; k++) cfg[k] = 8'h00;
  endtask

  task automatic put_cap(input int p, input logic [7:0] id, input logic [7:0] nx,
                         input logic [7:0] cl, input logic [7:0] kind,
                         input logic [7:0] bar, input logic [31:0] off,
                         input logic [31:0] len, input logic [31:0] mult);
    wr32(p, {kind, cl, nx, id});
    wr32(p + 4, {24'h0, bar});
    wr32(p + 8, off);
    wr32(p + 12, len);
    wr32(p + 16, mult);
  endtask

  // behavioural list walk giving expected outcome and read count
  task automatic model();
    int p, hops, t, b;
    bit [4:0] f;
    f = '0; exp_mult = '0; exp_err = 1'b0; exp_reads = 1; hops = 0;
    for (int k = 0; k < 5; k++) begin exp_bar[k] = '0; exp_off[k] = '0; exp_len[k] = '0; end
    p = cfg[8'h34] & 8'hFC;
    while (p != 0) begin
      if (hops == 48) begin exp_err = 1'b1; break; end
      hops++; exp_reads++;
      t = cfg[(p+3)&255];
      if (cfg[p] == 8'h09 && t >= 1 && t <= 5 && !f[t-1]) begin
        exp_reads++;
        b = cfg[(p+4)&255];
        if (b <= 5) begin
          exp_reads += 2;
          if (t == 2) begin exp_reads++; exp_mult = rd32(p + 16); end
          f[t-1] = 1'b1;
          exp_bar[t-1] = 3'(b);
          exp_off[t-1] = rd32(p + 8);
          exp_len[t-1] = rd32(p + 12);
        end
      end
      p = cfg[(p+1)&255] & 8'hFC;
    end
    exp_found = f;
  endtask

  // configuration responder: one answer per request, 0..2 cycles late
  initial begin
    forever begin
      @(negedge clk);
      cfg_rd_valid = 1'b0;
      if (cfg_rd_req) begin
        logic [7:0] a;
        int lat;
        a = cfg_rd_addr;
        rd_cnt++;
        lat = (int'(a[4:2]) + seed) % 3;
        repeat (lat) @(negedge clk);
        cfg_rd_data = rd32(a);
        cfg_rd_valid = 1'b1;
      end
    end
  end

  // every-clock comparison while a walk is running
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        chk((found & ~exp_found) == 5'd0, "R5", "slot found outside model", 32'(found), 32'(exp_found));
        chk(rd_cnt <= exp_reads, "R11", "reads exceed model", rd_cnt, exp_reads);
      end
    end
  end

  task automatic run_walk(input string name, input bit extra_start);
    int n;
    model();
    rd_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; running = 1'b1;
    if (extra_start) begin
      repeat (6) @(negedge clk);
      chk(busy == 1'b1, "R12", {name, " busy before extra start"}, 32'(busy), 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    running = 1'b0;
    chk(done == 1'b1, "R9", {name, " done pulse"}, 32'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", {name, " done one cycle"}, 32'(done), 0);
    chk(busy == 1'b0, "R9", {name, " idle after done"}, 32'(busy), 0);
    chk(found == exp_found, "R3", {name, " found mask"}, 32'(found), 32'(exp_found));
    chk(mandatory_ok == (exp_found[0] & exp_found[1] & exp_found[2] & exp_found[4]),
        "R8", {name, " mandatory"}, 32'(mandatory_ok),
        32'(exp_found[0] & exp_found[1] & exp_found[2] & exp_found[4]));
    chk(walk_err == exp_err, "R10", {name, " walk error"}, 32'(walk_err), 32'(exp_err));
    chk(rd_cnt == exp_reads, "R5", {name, " read count"}, rd_cnt, exp_reads);
    chk(notify_mult == exp_mult, "R6", {name, " notify multiplier"}, notify_mult, exp_mult);
    for (int k = 0; k < 5; k++) begin
      chk(ent_bar[k] == exp_bar[k], "R4", {name, " slot bar"}, 32'(ent_bar[k]), 32'(exp_bar[k]));
      chk(ent_off[k] == exp_off[k], "R5", {name, " slot offset"}, ent_off[k], exp_off[k]);
      chk(ent_len[k] == exp_len[k], "R5", {name, " slot length"}, ent_len[k], exp_len[k]);
    end
    seed++;
  endtask

  task automatic build_full();
    clear_cfg();
    cfg[8'h34] = 8'h40;
    put_cap(8'h40, 8'h09, 8'h58, 8'h10, 8'd1, 8'd0, 32'h0000_1000, 32'h38, 32'h0);
    put_cap(8'h58, 8'h09, 8'h70, 8'h14, 8'd2, 8'd2, 32'h0000_3000, 32'h400, 32'h4);
    put_cap(8'h70, 8'h09, 8'h88, 8'h10, 8'd3, 8'd1, 32'h0000_0010, 32'h1, 32'h0);
    put_cap(8'h88, 8'h09, 8'hA0, 8'h10, 8'd4, 8'd3, 32'h0000_2000, 32'h100, 32'h0);
    put_cap(8'hA0, 8'h09, 8'h00, 8'h14, 8'd5, 8'd0, 32'h0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "reset busy", 32'(busy), 0);
    chk(found == 5'd0, "R3", "reset found", 32'(found), 0);
    chk(cfg_rd_req == 1'b0, "R11", "reset no read", 32'(cfg_rd_req), 0);
    chk(walk_err == 1'b0, "R10", "reset error", 32'(walk_err), 0);

    // R1 R3 R6 R8: one entry per kind, all found
    build_full();
    run_walk("full", 1'b0);

    // R2 R4 R5 R7 R1: filters, masked start pointer, duplicates, oversized cap length
    clear_cfg();
    cfg[8'h34] = 8'h42;
    put_cap(8'h40, 8'h05, 8'h58, 8'h10, 8'd1, 8'd0, 32'hDEAD_0000, 32'h1, 32'h0);
    put_cap(8'h58, 8'h09, 8'h70, 8'h10, 8'd0, 8'd0, 32'hBAD0_0000, 32'h2, 32'h0);
    put_cap(8'h70, 8'h09, 8'h88, 8'h10, 8'd6, 8'd1, 32'hBAD1_0000, 32'h3, 32'h0);
    put_cap(8'h88, 8'h09, 8'hA0, 8'h10, 8'd1, 8'd7, 32'hBAD2_0000, 32'h4, 32'h0);
    put_cap(8'hA0, 8'h09, 8'hB8, 8'h10, 8'd1, 8'd4, 32'h0000_4000, 32'h38, 32'h0);
    put_cap(8'hB8, 8'h09, 8'hD0, 8'hFF, 8'd2, 8'd5, 32'h0000_5000, 32'h200, 32'h0);
    put_cap(8'hD0, 8'h09, 8'hE8, 8'h14, 8'd2, 8'd1, 32'hBAD3_0000, 32'h5, 32'h8);
    put_cap(8'hE8, 8'h09, 8'h00, 8'h10, 8'd3, 8'd2, 32'h0000_0020, 32'h4, 32'h0);
    run_walk("filter", 1'b0);

    // R8 R2: device kind absent, next pointer low bits masked
    build_full();
    cfg[8'h71] = 8'h8B;
    cfg[8'h8B] = 8'h00;
    put_cap(8'h88, 8'h11, 8'hA3, 8'h10, 8'd4, 8'd3, 32'h0, 32'h0, 32'h0);
    run_walk("nodev", 1'b0);

    // R1 R9: empty list
    clear_cfg();
    cfg[8'h34] = 8'h03;
    run_walk("empty", 1'b0);

    // R10: looping list
    clear_cfg();
    cfg[8'h34] = 8'h40;
    put_cap(8'h40, 8'h09, 8'h58, 8'h10, 8'd1, 8'd2, 32'h0000_6000, 32'h40, 32'h0);
    put_cap(8'h58, 8'h11, 8'h40, 8'h08, 8'd0, 8'd0, 32'h0, 32'h0, 32'h0);
    run_walk("loop", 1'b0);

    // R12: clean walk after error clears it; extra start ignored mid-walk
    build_full();
    run_walk("restart", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule